// File: doc/BRIEF.md
# Serial-Loaded Wiper Position Controller

This block is the digital core of a resistor-ladder potentiometer. A host writes a wiper code over a three-wire serial link made of an active-low select, a serial clock and a data line. The bits collect in a shift register. When the select is released, the register is copied into a wiper latch. The latch is decoded into a one-hot vector with one enable per ladder tap. Two flags control the end switches of the ladder: one opens the A end, and one shorts the wiper to the B end.

A single parameter chooses the variant. The wide variant takes an 8-bit word and drives 256 taps. The narrow variant takes a 6-bit word and drives 33 taps, and any code above the top tap saturates to that tap. After reset the wiper sits at midscale.

An active-low sleep input puts the ladder in its low-power state. In that state the latch keeps its value and the serial port still accepts writes, so the host can set a new position before it wakes the ladder. The serial and sleep pins are asynchronous to the system clock. They are brought into the system clock domain before any of them is used.

Top module: `serial_wiper_ctrl`

## Requirements
- R1: While select is low, each rising edge of the serial clock shifts the data bit into the bottom of the shift register, so a word arrives most significant bit first.
- R2: A rising edge of select copies the shift register into the wiper latch, and the tap vector follows the new code.
- R3: Serial clock edges while select is high leave the shift register unchanged. A following frame with no clock edges therefore reloads the earlier code.
- R4: After reset the latch holds midscale. In the wide variant that is code 128 (tap 128). In the narrow variant it is code 16 (tap 16).
- R5: While sleep_n is low, a_open and w_to_b are 1 and tap_sel has only bit 0 set. While sleep_n is high, both flags are 0.
- R6: The latch keeps its value through sleep. On wake, the wiper returns to the stored tap.
- R7: A word written while asleep takes effect as the wiper position after wake.
- R8: In the narrow variant, latched codes 33 to 63 select tap 32.
- R9: tap_sel always has exactly one bit set. When awake, that bit's index equals the code, with code 0 at tap 0 (the B end) and higher codes moving toward the A end.
- R10: A frame that is short or long loads whatever the shift register holds. Bits pushed past the top of the word are lost, so the latch takes the last word-width bits shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Serial select, active low; its rising edge loads the latch |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdata | input | 1 | Serial data, most significant bit first |
| sleep_n | input | 1 | Active-low ladder sleep |
| tap_sel | output | NUM_TAPS | One-hot tap enable; bit 0 is the B end |
| a_open | output | 1 | Opens the A-end switch |
| w_to_b | output | 1 | Shorts the wiper to the B end |

## Verification
The bench drives both variants from the same pins and sends 8-bit words. The wide instance checks straight decoding, while the same word's low six bits push the narrow instance past tap 32. A design without saturation would select no tap or the wrong tap there. Words written while asleep must not move the outputs until wake; a design that latched only when awake, or that cleared the latch in sleep, would come back at the wrong tap. Clock pulses sent with select high, followed by an empty frame, expose a shift register that still shifts while deselected. Short and long frames expose a register that clears at frame start or keeps the first bits of a long frame instead of the last.

// File: rtl/serial_wiper_ctrl.sv
module serial_wiper_ctrl #(
  parameter bit WIDE = 1'b1,
  localparam int WORD_W = WIDE ? 8 : 6,
  localparam int NUM_TAPS = WIDE ? 256 : 33
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_n,
  input  logic                sclk,
  input  logic                sdata,
  input  logic                sleep_n,
  output logic [NUM_TAPS-1:0] tap_sel,
  output logic                a_open,
  output logic                w_to_b
);
  localparam int TOP_CODE = NUM_TAPS - 1;
  localparam logic [WORD_W-1:0] MID = WORD_W'(NUM_TAPS / 2);

  logic [3:0] meta, sync;
  logic cs_q, ck_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta <= 4'b1001;
      sync <= 4'b1001;
      cs_q <= 1'b1;
      ck_q <= 1'b0;
    end else begin
      meta <= {sel_n, sclk, sdata, sleep_n};
      sync <= meta;
      cs_q <= sync[3];
      ck_q <= sync[2];
    end

  wire cs_s    = sync[3];
  wire ck_s    = sync[2];
  wire dt_s    = sync[1];
  wire awake   = sync[0];
  wire ck_rise = ck_s & ~ck_q;
  wire cs_rise = cs_s & ~cs_q;

  logic [WORD_W-1:0] shreg, latch, code;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg <= '0;
      latch <= MID;
    end else begin
      if (!cs_s && ck_rise) shreg <= {shreg[WORD_W-2:0], dt_s};
      if (cs_rise) latch <= shreg;
    end

  generate
    if (NUM_TAPS < (1 << WORD_W)) begin : g_sat
      assign code = (latch > WORD_W'(TOP_CODE)) ? WORD_W'(TOP_CODE) : latch;

      assert_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (latch > WORD_W'(TOP_CODE) && !a_open) |-> tap_sel[TOP_CODE]);
    end else begin : g_full
      assign code = latch;
    end
  endgenerate

  always_comb begin
    tap_sel = '0;
    if (awake) tap_sel[code] = 1'b1;
    else       tap_sel[0]    = 1'b1;
  end

  assign a_open = ~awake;
  assign w_to_b = ~awake;

  assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1);

  assert_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    a_open |-> (tap_sel[0] && w_to_b));

  assert_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && ck_rise) |=> shreg[0] == $past(dt_s));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> $stable(shreg));

  assert_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(latch));
endmodule

// File: tb/sim_serial_wiper_ctrl.sv
`timescale 1ns/1ps
module sim_serial_wiper_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sclk = 1'b0, sdata = 1'b0, sleep_n = 1'b1;
  logic [255:0] tw;
  logic [32:0]  tn;
  logic aw, bw, an, bn;

  always #2.5 clk = ~clk;

  serial_wiper_ctrl #(.WIDE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdata(sdata),
    .sleep_n(sleep_n), .tap_sel(tw), .a_open(aw), .w_to_b(bw));

  serial_wiper_ctrl #(.WIDE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdata(sdata),
    .sleep_n(sleep_n), .tap_sel(tn), .a_open(an), .w_to_b(bn));

  int total = 0, bad = 0;
  int qw[$], qn[$];
  bit qs[$];
  string qt[$];
  int sr = 0, lat = 128, lat_n = 16;
  bit asleep = 1'b0;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input string tag);
    qw.push_back(lat & 255);
    qn.push_back(lat_n);
    qs.push_back(asleep);
    qt.push_back(tag);
  endtask

  task automatic send(input logic [15:0] v, input int n, input string tag);
    sel_n = 1'b0;
    wait_clk(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = v[i];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
      sr = (sr << 1) | int'(v[i]);
    end
    wait_clk(4);
    sel_n = 1'b1;
    lat = sr & 255;
    lat_n = ((sr & 63) > 32) ? 32 : (sr & 63);
    wait_clk(8);
    expect_now(tag);
  endtask

  task automatic set_sleep(input bit s, input string tag);
    sleep_n = ~s;
    asleep = s;
    wait_clk(6);
    expect_now(tag);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (qw.size() > 0) begin
        int ew, en;
        bit es;
        string tg;
        logic [255:0] xw;
        logic [32:0] xn;
        ew = qw.pop_front(); en = qn.pop_front();
        es = qs.pop_front(); tg = qt.pop_front();
        xw = es ? 256'd1 : (256'd1 << ew);
        xn = es ? 33'd1 : (33'd1 << en);
        total++;
        if (tw !== xw || aw !== es || bw !== es) begin
          bad++;
          $display("FAIL %s wide: tap=%h a_open=%b w_to_b=%b expected tap=%h flags=%b",
                   tg, tw, aw, bw, xw, es);
        end
        total++;
        if (tn !== xn || an !== es || bn !== es) begin
          bad++;
          $display("FAIL %s narrow: tap=%h a_open=%b w_to_b=%b expected tap=%h flags=%b",
                   tg, tn, an, bn, xn, es);
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    expect_now("R4 midscale after reset");
    send(16'h0A, 8, "R1 R2 R9 word 0x0A");
    send(16'hE5, 8, "R8 R1 word 0xE5");
    send(16'h21, 8, "R8 code 33");
    send(16'h20, 8, "R8 code 32");
    send(16'h00, 8, "R9 code 0 at B end");
    send(16'hFF, 8, "R8 R9 all ones");
    set_sleep(1'b1, "R5 sleep entered");
    set_sleep(1'b0, "R6 wake restores stored tap");
    set_sleep(1'b1, "R5 sleep again");
    send(16'h47, 8, "R7 write during sleep holds outputs");
    set_sleep(1'b0, "R7 wake applies new word");
    for (int k = 0; k < 5; k++) begin
      sdata = k[0];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(6);
    expect_now("R3 clocks with select high no change");
    send(16'h0, 0, "R3 empty frame reloads unchanged register");
    send(16'h5, 3, "R10 short frame");
    send(16'h306, 10, "R10 long frame keeps last bits");
    send(16'h1, 1, "R10 one-bit frame");
    wait_clk(4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule